// File: doc/BRIEF.md
# I/O Interrupt Redirection Controller

This block gathers a set of interrupt input pins and turns each one into an outgoing interrupt message. Every pin has its own redirection entry. The entry supplies the message vector, the delivery mode and the destination processor ID. It also sets how the pin is sensed: edge or level, active high or active low, and masked or unmasked. Messages leave on a valid/ready port. When several pins are ready in the same cycle, the lowest pin index is served first.

Software reaches the entries through an indirect pair of registers. It writes an internal register number into the index register. It then reads or writes that internal register through the data window. A read-only version word reports the version and the highest pin number.

Level-triggered entries support service acknowledgement. After a level message is accepted, the entry stays blocked until software writes that entry's vector to the end-of-interrupt register. One such write re-arms every level entry that holds the same vector, so several level pins can share a vector. Edge events that arrive while an entry is masked are dropped.

Top module: `irq_redirect_ctrl`

## Requirements
- R1: Window index 0x01 reads as the version word. VERSION_ID is in bits 7:0, NUM_PINS-1 is in bits 23:16, and the other bits are zero. Window writes to this index have no effect.
- R2: A write to bus address 0x00 sets the index register (bits 7:0). A read of address 0x00 returns the index. Address 0x10 reads or writes the internal register the index selects. Read data appears on bus_rdata the cycle after bus_re. Unmapped indices read as zero.
- R3: Entry n has its low word at index 0x10+2n and its high word at index 0x11+2n. The low word holds:
  - the vector in bits 7:0;
  - the delivery mode in bits 10:8;
  - polarity in bit 13 (1 = active low);
  - trigger in bit 15 (1 = level);
  - mask in bit 16 (1 = masked).

  The high word holds the destination in bits 31:16. All other bits read as zero.
- R4: After reset, every low word reads 0x00010000 (masked), every high word reads 0, and msg_valid is low.
- R5: A message carries the vector, mode and destination of its entry. These fields and msg_valid hold steady while msg_ready is low.
- R6: An unmasked edge entry sends exactly one message for each inactive-to-active transition of its pin. A pin held active sends nothing more.
- R7: An edge transition that occurs while the entry is masked is dropped. No message follows the later unmask.
- R8: An active-low entry treats the falling input as its event. The rising input sends nothing.
- R9: An unmasked level entry with an active pin sends one message. It then sends nothing more until a bus write to address 0x40 whose bits 7:0 equal its vector. A write to 0x40 with a different vector leaves it blocked.
- R10: One end-of-interrupt write re-arms every level entry that holds the written vector.
- R11: When several entries are ready together, messages are issued in ascending pin order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | NUM_PINS | Interrupt input pins |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Register address (0x00 index, 0x10 window, 0x40 end-of-interrupt) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| msg_valid | output | 1 | Message available |
| msg_ready | input | 1 | Message taken by the receiver |
| msg_vector | output | 8 | Message vector |
| msg_mode | output | 3 | Message delivery mode |
| msg_dest | output | 16 | Destination processor ID (ID high byte, extended ID low byte) |

## Verification
The assertions assume the following about the inputs:
- bus_we and bus_re are single-cycle strobes whose address and data are steady at the sampling edge.
- msg_ready is a level that the receiver may hold low for any length of time.
- Polarity is not flipped while a pin is active.

The stimulus keeps to these assumptions in several ways. Every bus access is issued from a task on the falling clock. An entry's input pin is set to its inactive level before the entry is reprogrammed. Ready is held low across several cycles in at least one case, so the hold property is exercised.

// File: rtl/irc_pkg.sv
package irc_pkg;
  // bus register addresses
  localparam int REG_INDEX  = 'h00;
  localparam int REG_WINDOW = 'h10;
  localparam int REG_EOI    = 'h40;
  // internal register indices
  localparam int IDX_VERSION = 'h01;
  localparam int IDX_ENTRY0  = 'h10;

  typedef struct packed {
    logic [15:0] dest;
    logic        mask;
    logic        trig;   // 1 = level
    logic        pol;    // 1 = active low
    logic [2:0]  mode;
    logic [7:0]  vec;
  } entry_t;

  typedef struct packed {
    logic [7:0]  vec;
    logic [2:0]  mode;
    logic [15:0] dest;
  } payload_t;

  localparam entry_t ENTRY_RESET = '{dest: 16'h0, mask: 1'b1, trig: 1'b0,
                                     pol: 1'b0, mode: 3'h0, vec: 8'h0};
endpackage

// File: rtl/irc_regfile.sv
module irc_regfile
  import irc_pkg::*;
#(
  parameter int          NUM_PINS   = 8,
  parameter logic [7:0]  VERSION_ID = 8'h21,
  parameter int          ADDR_W     = 7
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      bus_we,
  input  logic                      bus_re,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic [31:0]               bus_wdata,
  output logic [31:0]               bus_rdata,
  output entry_t [NUM_PINS-1:0]     ents,
  output logic                      eoi_valid,
  output logic [7:0]                eoi_vec
);
  localparam logic [7:0] MAX_PIN = 8'(NUM_PINS - 1);

  logic [7:0]            index_q;
  entry_t [NUM_PINS-1:0] ent_q;
  logic [31:0]           win_data;
  logic                  win_we;
  logic                  unused_wbits;

  assign win_we       = bus_we && (bus_addr == ADDR_W'(REG_WINDOW));
  assign eoi_valid    = bus_we && (bus_addr == ADDR_W'(REG_EOI));
  assign eoi_vec      = bus_wdata[7:0];
  assign unused_wbits = ^{bus_wdata[14], bus_wdata[12:11]};
  assign ents         = ent_q;

  always_ff @(posedge clk) begin
    if (rst)
      index_q <= 8'h0;
    else if (bus_we && bus_addr == ADDR_W'(REG_INDEX))
      index_q <= bus_wdata[7:0];
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_PINS; i++) begin
      if (rst) begin
        ent_q[i] <= ENTRY_RESET;
      end else if (win_we && index_q == 8'(IDX_ENTRY0 + 2*i)) begin
        ent_q[i].vec  <= bus_wdata[7:0];
        ent_q[i].mode <= bus_wdata[10:8];
        ent_q[i].pol  <= bus_wdata[13];
        ent_q[i].trig <= bus_wdata[15];
        ent_q[i].mask <= bus_wdata[16];
      end else if (win_we && index_q == 8'(IDX_ENTRY0 + 2*i + 1)) begin
        ent_q[i].dest <= bus_wdata[31:16];
      end
    end
  end

  always_comb begin
    win_data = 32'h0;
    if (index_q == 8'(IDX_VERSION))
      win_data = {8'h0, MAX_PIN, 8'h0, VERSION_ID};
    for (int i = 0; i < NUM_PINS; i++) begin
      if (index_q == 8'(IDX_ENTRY0 + 2*i))
        win_data = {15'h0, ent_q[i].mask, ent_q[i].trig, 1'b0, ent_q[i].pol,
                    2'b00, ent_q[i].mode, ent_q[i].vec};
      if (index_q == 8'(IDX_ENTRY0 + 2*i + 1))
        win_data = {ent_q[i].dest, 16'h0};
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      bus_rdata <= 32'h0;
    else if (bus_re) begin
      if (bus_addr == ADDR_W'(REG_INDEX))
        bus_rdata <= {24'h0, index_q};
      else if (bus_addr == ADDR_W'(REG_WINDOW))
        bus_rdata <= win_data;
      else
        bus_rdata <= 32'h0;
    end
  end

  // R1: reserved bytes of the version word read as zero
  assert_version_reserved_R1: assert property (@(posedge clk) disable iff (rst)
    (bus_re && bus_addr == ADDR_W'(REG_WINDOW) && index_q == 8'(IDX_VERSION))
      |=> (bus_rdata[15:8] == 8'h0 && bus_rdata[31:24] == 8'h0));
endmodule

// File: rtl/irc_pin.sv
module irc_pin (
  input  logic       clk,
  input  logic       rst,
  input  logic       pin_in,
  input  logic       pol,
  input  logic       trig,
  input  logic       mask,
  input  logic [7:0] vec,
  input  logic       eoi_valid,
  input  logic [7:0] eoi_vec,
  input  logic       take,
  output logic       req
);
  logic pin_q, act_d, edge_pend, in_serv;
  logic act, eoi_hit;

  assign act     = pin_q ^ pol;
  assign eoi_hit = eoi_valid && (eoi_vec == vec);

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_q <= 1'b0;
      act_d <= 1'b0;
    end else begin
      pin_q <= pin_in;
      act_d <= act;
    end
  end

  // edge capture: discarded while masked
  always_ff @(posedge clk) begin
    if (rst || mask || trig)
      edge_pend <= 1'b0;
    else if (act && !act_d)
      edge_pend <= 1'b1;
    else if (take)
      edge_pend <= 1'b0;
  end

  // level service flag: set on accept, cleared by matching end-of-interrupt
  always_ff @(posedge clk) begin
    if (rst)
      in_serv <= 1'b0;
    else if (take && trig)
      in_serv <= 1'b1;
    else if (eoi_hit || !trig)
      in_serv <= 1'b0;
  end

  assign req = trig ? (act && !mask && !in_serv) : edge_pend;

  // R7: an edge can only be captured while unmasked
  assert_edge_unmasked_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(edge_pend) |-> $past(!mask));

  // R9: service flag only released by end-of-interrupt with this vector
  assert_service_release_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(in_serv) |-> $past(eoi_hit || !trig));
endmodule

// File: rtl/irc_msg_arb.sv
module irc_msg_arb
  import irc_pkg::*;
#(
  parameter int NUM_PINS = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NUM_PINS-1:0]     req,
  input  payload_t [NUM_PINS-1:0] payload,
  input  logic                    msg_ready,
  output logic                    msg_valid,
  output logic [7:0]              msg_vector,
  output logic [2:0]              msg_mode,
  output logic [15:0]             msg_dest,
  output logic [NUM_PINS-1:0]     take
);
  localparam int SEL_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;

  logic [SEL_W-1:0] pick, sel_q;
  logic             found;

  always_comb begin
    pick  = '0;
    found = 1'b0;
    for (int i = NUM_PINS - 1; i >= 0; i--) begin
      if (req[i]) begin
        pick  = SEL_W'(i);
        found = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      msg_valid  <= 1'b0;
      msg_vector <= 8'h0;
      msg_mode   <= 3'h0;
      msg_dest   <= 16'h0;
      sel_q      <= '0;
    end else if (msg_valid && msg_ready) begin
      msg_valid <= 1'b0;
    end else if (!msg_valid && found) begin
      msg_valid  <= 1'b1;
      msg_vector <= payload[pick].vec;
      msg_mode   <= payload[pick].mode;
      msg_dest   <= payload[pick].dest;
      sel_q      <= pick;
    end
  end

  always_comb begin
    take = '0;
    if (msg_valid && msg_ready)
      take[sel_q] = 1'b1;
  end

  // R5: an offered message holds until taken
  assert_msg_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_vector) &&
                                   $stable(msg_mode) && $stable(msg_dest)));

  // R11: at most one pin is acknowledged per accept
  assert_single_take_R11: assert property (@(posedge clk) disable iff (rst)
    $onehot0(take));

  // R6: a message only appears when some pin requested it
  assert_msg_has_source_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(msg_valid) |-> $past(req != '0));
endmodule

// File: rtl/irq_redirect_ctrl.sv
module irq_redirect_ctrl
  import irc_pkg::*;
#(
  parameter int         NUM_PINS   = 8,
  parameter logic [7:0] VERSION_ID = 8'h21,
  parameter int         ADDR_W     = 7
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] irq_in,
  input  logic                bus_we,
  input  logic                bus_re,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  output logic                msg_valid,
  input  logic                msg_ready,
  output logic [7:0]          msg_vector,
  output logic [2:0]          msg_mode,
  output logic [15:0]         msg_dest
);
  entry_t   [NUM_PINS-1:0] ents;
  payload_t [NUM_PINS-1:0] payload;
  logic     [NUM_PINS-1:0] req, take;
  logic                    eoi_valid;
  logic     [7:0]          eoi_vec;

  irc_regfile #(
    .NUM_PINS(NUM_PINS), .VERSION_ID(VERSION_ID), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_re(bus_re),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ents(ents), .eoi_valid(eoi_valid), .eoi_vec(eoi_vec)
  );

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    irc_pin u_pin (
      .clk(clk), .rst(rst), .pin_in(irq_in[g]),
      .pol(ents[g].pol), .trig(ents[g].trig), .mask(ents[g].mask),
      .vec(ents[g].vec), .eoi_valid(eoi_valid), .eoi_vec(eoi_vec),
      .take(take[g]), .req(req[g])
    );
    assign payload[g] = '{vec: ents[g].vec, mode: ents[g].mode, dest: ents[g].dest};
  end

  irc_msg_arb #(.NUM_PINS(NUM_PINS)) u_arb (
    .clk(clk), .rst(rst), .req(req), .payload(payload),
    .msg_ready(msg_ready), .msg_valid(msg_valid), .msg_vector(msg_vector),
    .msg_mode(msg_mode), .msg_dest(msg_dest), .take(take)
  );
endmodule

// File: tb/sim_irq_redirect_ctrl.sv
`timescale 1ns/1ps
module sim_irq_redirect_ctrl;
  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [N-1:0] irq_in = '0;
  logic        bus_we = 1'b0, bus_re = 1'b0;
  logic [6:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        msg_valid, msg_ready = 1'b0;
  logic [7:0]  msg_vector;
  logic [2:0]  msg_mode;
  logic [15:0] msg_dest;

  int checks = 0, fails = 0, cycles = 0;
  bit done = 0;

  always #2 clk = ~clk;

  irq_redirect_ctrl #(.NUM_PINS(N), .VERSION_ID(8'h21), .ADDR_W(7)) u0 (
    .clk(clk), .rst(rst), .irq_in(irq_in), .bus_we(bus_we), .bus_re(bus_re),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_vector(msg_vector),
    .msg_mode(msg_mode), .msg_dest(msg_dest)
  );

  // {index, write data, expected readback}
  localparam logic [71:0] TBL [0:7] = '{
    {8'h10, 32'hFFFF_FFFF, 32'h0001_A7FF},
    {8'h11, 32'hFFFF_FFFF, 32'hFFFF_0000},
    {8'h12, 32'h0000_0342, 32'h0000_0342},
    {8'h13, 32'h1234_5678, 32'h1234_0000},
    {8'h01, 32'hFFFF_FFFF, 32'h0007_0021},
    {8'h1F, 32'hABCD_0001, 32'hABCD_0000},
    {8'h05, 32'hFFFF_FFFF, 32'h0000_0000},
    {8'h20, 32'hFFFF_FFFF, 32'h0000_0000}
  };

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk); bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    @(negedge clk); bus_re = 1'b1; bus_addr = a;
    @(negedge clk); bus_re = 1'b0; d = bus_rdata;
  endtask

  task automatic win_wr(input logic [7:0] idx, input logic [31:0] d);
    wr(7'h00, {24'h0, idx}); wr(7'h10, d);
  endtask

  task automatic win_rd(input logic [7:0] idx, output logic [31:0] d);
    wr(7'h00, {24'h0, idx}); rd(7'h10, d);
  endtask

  function automatic logic [31:0] lo(input logic [7:0] v, input logic [2:0] m,
                                     input bit p, input bit t, input bit k);
    return {15'h0, k, t, 1'b0, p, 2'b00, m, v};
  endfunction

  task automatic prog(input int pin, input logic [31:0] low, input logic [15:0] dest);
    win_wr(8'(8'h11 + 2*pin), {dest, 16'h0});
    win_wr(8'(8'h10 + 2*pin), low);
  endtask

  // wait up to 20 cycles for a message, optionally hold it, then accept it
  task automatic get_msg(input int hold, output bit got, output logic [26:0] f);
    got = 0; f = '0;
    for (int i = 0; i < 20 && !got; i++) begin
      @(negedge clk);
      if (msg_valid) begin got = 1; f = {msg_vector, msg_mode, msg_dest}; end
    end
    if (got) begin
      for (int i = 0; i < hold; i++) begin
        @(negedge clk);
        chk(msg_valid && {msg_vector, msg_mode, msg_dest} == f, "R5 hold",
            {5'h0, msg_vector, msg_mode, msg_dest}, {5'h0, f});
      end
      msg_ready = 1'b1; @(negedge clk); msg_ready = 1'b0;
    end
  endtask

  task automatic quiet(input string req);
    bit seen = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (msg_valid) seen = 1;
    end
    chk(!seen, req, {31'h0, seen}, 32'h0);
    if (seen) begin msg_ready = 1'b1; @(negedge clk); msg_ready = 1'b0; end
  endtask

  task automatic expect_msg(input string req, input logic [7:0] v,
                            input logic [2:0] m, input logic [15:0] d, input int hold);
    bit got; logic [26:0] f;
    get_msg(hold, got, f);
    chk(got && f == {v, m, d}, req, {4'h0, got, f}, {5'h1, v, m, d});
  endtask

  initial begin : watchdog
    while (!done) begin
      @(posedge clk); cycles++;
      if (cycles > 100000) begin
        chk(0, "watchdog", cycles, 100000);
        report();
      end
    end
  end

  initial begin : stim
    logic [31:0] d;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R4: reset state
    chk(!msg_valid, "R4 msg_valid", {31'h0, msg_valid}, 0);
    for (int p = 0; p < N; p += 7) begin
      win_rd(8'(8'h10 + 2*p), d); chk(d == 32'h0001_0000, "R4 low", d, 32'h0001_0000);
      win_rd(8'(8'h11 + 2*p), d); chk(d == 32'h0, "R4 high", d, 32'h0);
    end

    // R2: index readback
    wr(7'h00, 32'h0000_0013); rd(7'h00, d);
    chk(d == 32'h13, "R2 index", d, 32'h13);

    // R1 R2 R3: table of window writes and readbacks
    for (int t = 0; t < 8; t++) begin
      win_wr(TBL[t][71:64], TBL[t][63:32]);
      win_rd(TBL[t][71:64], d);
      chk(d == TBL[t][31:0], "R1/R2/R3 table", d, TBL[t][31:0]);
    end
    quiet("R3 no stray message");

    // R6 R5: edge entry on pin 1, lowest-priority mode
    prog(1, lo(8'h41, 3'd1, 0, 0, 0), 16'h0A05);
    @(negedge clk); irq_in[1] = 1'b1;
    expect_msg("R6 edge first", 8'h41, 3'd1, 16'h0A05, 3);
    quiet("R6 held pin single message");
    @(negedge clk); irq_in[1] = 1'b0;
    @(negedge clk); irq_in[1] = 1'b1;
    expect_msg("R6 edge second", 8'h41, 3'd1, 16'h0A05, 0);
    irq_in[1] = 1'b0;
    prog(1, lo(8'h41, 3'd1, 0, 0, 1), 16'h0A05);

    // R7: masked edge dropped
    prog(0, lo(8'h30, 3'd0, 0, 0, 1), 16'h0100);
    @(negedge clk); irq_in[0] = 1'b1;
    repeat (3) @(negedge clk); irq_in[0] = 1'b0;
    repeat (3) @(negedge clk);
    prog(0, lo(8'h30, 3'd0, 0, 0, 0), 16'h0100);
    quiet("R7 masked edge dropped");
    @(negedge clk); irq_in[0] = 1'b1;
    expect_msg("R7 unmasked edge delivered", 8'h30, 3'd0, 16'h0100, 0);
    irq_in[0] = 1'b0;
    prog(0, lo(8'h30, 3'd0, 0, 0, 1), 16'h0100);

    // R8: active-low edge on pin 7
    irq_in[7] = 1'b1;
    repeat (3) @(negedge clk);
    prog(7, lo(8'h77, 3'd4, 1, 0, 0), 16'h0707);
    quiet("R8 idle high no message");
    @(negedge clk); irq_in[7] = 1'b0;
    expect_msg("R8 falling event", 8'h77, 3'd4, 16'h0707, 0);
    @(negedge clk); irq_in[7] = 1'b1;
    quiet("R8 rising ignored");
    prog(7, lo(8'h77, 3'd4, 1, 0, 1), 16'h0707);

    // R9: level entry with end-of-interrupt
    prog(2, lo(8'h55, 3'd0, 0, 1, 0), 16'h0202);
    @(negedge clk); irq_in[2] = 1'b1;
    expect_msg("R9 level first", 8'h55, 3'd0, 16'h0202, 0);
    quiet("R9 blocked in service");
    wr(7'h40, 32'h66);
    quiet("R9 other vector no effect");
    wr(7'h40, 32'h55);
    expect_msg("R9 re-armed", 8'h55, 3'd0, 16'h0202, 0);
    irq_in[2] = 1'b0;
    wr(7'h40, 32'h55);
    quiet("R9 inactive pin after eoi");
    prog(2, lo(8'h55, 3'd0, 0, 1, 1), 16'h0202);

    // R10 R11: shared level vector on pins 3 and 4
    prog(3, lo(8'h60, 3'd0, 0, 1, 0), 16'h0300);
    prog(4, lo(8'h60, 3'd0, 0, 1, 0), 16'h0400);
    @(negedge clk); irq_in[3] = 1'b1; irq_in[4] = 1'b1;
    expect_msg("R11 shared first pin3", 8'h60, 3'd0, 16'h0300, 0);
    expect_msg("R11 shared second pin4", 8'h60, 3'd0, 16'h0400, 0);
    quiet("R10 both blocked");
    wr(7'h40, 32'h60);
    expect_msg("R10 re-arm pin3", 8'h60, 3'd0, 16'h0300, 0);
    expect_msg("R10 re-arm pin4", 8'h60, 3'd0, 16'h0400, 0);
    irq_in[3] = 1'b0; irq_in[4] = 1'b0;
    prog(3, lo(8'h60, 3'd0, 0, 1, 1), 16'h0300);
    prog(4, lo(8'h60, 3'd0, 0, 1, 1), 16'h0400);

    // R11: simultaneous edges on pins 6 and 5
    prog(5, lo(8'h85, 3'd0, 0, 0, 0), 16'h0505);
    prog(6, lo(8'h86, 3'd0, 0, 0, 0), 16'h0606);
    @(negedge clk); irq_in[6] = 1'b1; irq_in[5] = 1'b1;
    expect_msg("R11 pin5 first", 8'h85, 3'd0, 16'h0505, 0);
    expect_msg("R11 pin6 second", 8'h86, 3'd0, 16'h0606, 0);
    quiet("R11 no extra");

    done = 1;
    report();
  end
endmodule